// File: doc/BRIEF.md
# Private Interrupt Pending-Event Unit

This unit keeps the pending state of the thirty-two interrupts that belong to one processor. The upper sixteen come from external wires. The lower sixteen are software-generated and arrive as one request per cycle. Each request carries an interrupt number, the group it asks for, and a flag that marks it as non-secure. The unit decides whether each request may raise its interrupt. It watches the wires for rising edges, keeps one pending bit per interrupt, and reports every bit it sets as a one-cycle pulse, so that a register bank can mirror the state.

Each request is checked against three things: the group programmed for the target interrupt, a two-bit non-secure access level held for each software interrupt, and a global flag that turns security off. A wire raises its interrupt only when that wire is programmed as edge-sensitive. Software can clear pending bits with a clear mask. Arbitration by priority and delivery to the processor are handled elsewhere.

Top module: `priv_irq_pend`

## Requirements
- R1: A synchronous active-high reset clears `pend_q`, `pend_set`, `req_ack`, `req_nak` and the stored wire levels. A wire that is high when reset ends is therefore seen as a fresh rising edge on the first cycle after reset.
- R2: Line j (bit j of `line_lvl`, interrupt 16+j) sets pending bit 16+j when both of these hold:
  - the line is high while its stored level is low;
  - `cfg_edge[j]` is 1.

  The new pending bit and the matching bit of `pend_set` appear one cycle later.
- R3: A line that is level-sensitive (`cfg_edge[j]`=0) never produces a pulse. A line sample equal to the stored level causes no event.
- R4: A request whose `req_id` is 16 or more is rejected (`req_nak`) and sets nothing.
- R5: The group encoding is 0 = group 0, 1 = secure group 1 and 2 = non-secure group 1.
  - With security on, an interrupt's configured group is 2 when `cfg_group` is 1. Otherwise it is 1 when `cfg_grpmod` is 1, and 0 when `cfg_grpmod` is 0.
  - A request for group 1 aimed at an interrupt configured as group 0 is handled as a group-0 request.
- R6: After that adjustment, a request whose group differs from the configured group is rejected. Request group 3 never matches.
- R7: With security on (`cfg_secdis`=0), a non-secure request reads the access level at `cfg_nsacc[2*id+1:2*id]`.
  - A group-0 target needs a level of 1 or more.
  - A secure group-1 target needs a level of 2 or more.
  - A non-secure group-1 target needs no particular level.
  - A request that fails its check is rejected.
- R8: With `cfg_secdis`=1, the access level is not checked. The configured group is 2 when `cfg_group` is 1 and 0 otherwise; `cfg_grpmod` is ignored.
- R9: An accepted request sets pending bit `req_id`, and pulses that bit of `pend_set` one cycle later. Software interrupt bits of `pend_set` never pulse without an accepted request.
- R10: `pend_clr` clears pending bits on the next edge. When a set and a clear hit the same bit in the same cycle, the set wins.
- R11: Every request produces exactly one of `req_ack` or `req_nak` one cycle later. Neither is raised in a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_lvl | input | 16 | Levels of external interrupt lines 16..31 |
| req_valid | input | 1 | Software interrupt request present |
| req_id | input | 5 | Requested interrupt number |
| req_grp | input | 2 | Requested group (0, 1 secure, 2 non-secure) |
| req_ns | input | 1 | Request issued from the non-secure side |
| cfg_group | input | 16 | Group bit per software interrupt |
| cfg_grpmod | input | 16 | Group modifier per software interrupt |
| cfg_edge | input | 16 | Edge-sensitive flag per external line |
| cfg_nsacc | input | 32 | Two-bit non-secure access level per software interrupt |
| cfg_secdis | input | 1 | Security disabled |
| pend_clr | input | 32 | Software clear mask for pending bits |
| pend_q | output | 32 | Pending bits |
| pend_set | output | 32 | One-cycle pulse per pending bit set |
| req_ack | output | 1 | Previous-cycle request accepted |
| req_nak | output | 1 | Previous-cycle request rejected |

## Verification
The bench goes after the corner cases where a wrong design would still look plausible:
- Secure group-1 requests aimed at group-0 interrupts. A design that skips the group adjustment would reject them.
- Access levels of exactly 0, 1 and 2. An off-by-one comparison would either let a non-secure group-0 request in at level 0, or let a secure group-1 request in at level 1.
- The security-off case. A design that still checks access there would drop valid requests.
- Request numbers 16 to 19. A design that truncates the number would wrongly hit interrupts 0 to 3.
- A wire held high across reset, and a clear that coincides with a set. These expose a stored level that is not reset, and a clear given priority over a set.

// File: rtl/pip_pkg.sv
package pip_pkg;

  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2,
    GRP_BAD  = 2'd3
  } grp_e;

  // Configured group of one interrupt from its group bit, modifier and
  // the global security-off flag.
  function automatic grp_e cfg_to_grp(input logic grp_bit,
                                      input logic mod_bit,
                                      input logic sec_off);
    grp_e g;
    if (grp_bit)                 g = GRP_G1NS;
    else if (mod_bit && !sec_off) g = GRP_G1S;
    else                         g = GRP_G0;
    return g;
  endfunction

endpackage

// File: rtl/pip_line_edge.sv
module pip_line_edge #(
  parameter int NUM_LINE = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_LINE-1:0] line_lvl,
  input  logic [NUM_LINE-1:0] edge_mode,
  output logic [NUM_LINE-1:0] rise_set
);

  logic [NUM_LINE-1:0] lvl_q;

  for (genvar i = 0; i < NUM_LINE; i++) begin : g_line
    // Stored level only moves when the sample differs from it.
    always_ff @(posedge clk) begin
      if (rst)
        lvl_q[i] <= 1'b0;
      else if (line_lvl[i] != lvl_q[i])
        lvl_q[i] <= line_lvl[i];
    end

    assign rise_set[i] = line_lvl[i] & ~lvl_q[i] & edge_mode[i];
  end

endmodule

// File: rtl/pip_sgi_gate.sv
module pip_sgi_gate
  import pip_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int ID_W    = 5,
  parameter int ACC_W   = 2
) (
  input  logic                     req_valid,
  input  logic [ID_W-1:0]          req_id,
  input  logic [1:0]               req_grp,
  input  logic                     req_ns,
  input  logic [NUM_SGI-1:0]       cfg_group,
  input  logic [NUM_SGI-1:0]       cfg_grpmod,
  input  logic [ACC_W*NUM_SGI-1:0] cfg_nsacc,
  input  logic                     cfg_secdis,
  output logic                     accept,
  output logic                     reject,
  output logic [NUM_SGI-1:0]       sgi_set
);

  localparam int IDX_W = $clog2(NUM_SGI);

  logic             id_ok;
  logic [IDX_W-1:0] idx;
  grp_e             conf_grp;
  grp_e             want_grp;
  logic [ACC_W-1:0] acc_lvl;
  logic             grp_ok;
  logic             acc_ok;

  assign id_ok = (req_id < ID_W'(NUM_SGI));
  assign idx   = req_id[IDX_W-1:0];

  always_comb begin
    conf_grp = cfg_to_grp(cfg_group[idx], cfg_grpmod[idx], cfg_secdis);
    want_grp = grp_e'(req_grp);
    // A secure group-1 request lands on a group-0 interrupt as group 0.
    if (want_grp == GRP_G1S && conf_grp == GRP_G0)
      want_grp = GRP_G0;
    grp_ok  = (want_grp == conf_grp);
    acc_lvl = cfg_nsacc[idx*ACC_W +: ACC_W];
    acc_ok  = 1'b1;
    if (req_ns && !cfg_secdis) begin
      if (conf_grp == GRP_G0  && acc_lvl < ACC_W'(1)) acc_ok = 1'b0;
      if (conf_grp == GRP_G1S && acc_lvl < ACC_W'(2)) acc_ok = 1'b0;
    end
  end

  assign accept = req_valid & id_ok & grp_ok & acc_ok;
  assign reject = req_valid & ~accept;

  for (genvar s = 0; s < NUM_SGI; s++) begin : g_dec
    assign sgi_set[s] = accept && (idx == IDX_W'(s));
  end

endmodule

// File: rtl/pip_pend_bank.sv
module pip_pend_bank #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] set_now,
  input  logic [NUM_IRQ-1:0] clr_now,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic [NUM_IRQ-1:0] set_q
);

  for (genvar b = 0; b < NUM_IRQ; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[b] <= 1'b0;
        set_q[b]  <= 1'b0;
      end else begin
        set_q[b] <= set_now[b];
        // set has priority over a coincident clear
        if (set_now[b])      pend_q[b] <= 1'b1;
        else if (clr_now[b]) pend_q[b] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/priv_irq_pend.sv
module priv_irq_pend #(
  parameter int NUM_SGI  = 16,
  parameter int NUM_LINE = 16,
  parameter int ID_W     = 5,
  parameter int ACC_W    = 2,
  localparam int NUM_IRQ = NUM_SGI + NUM_LINE
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_LINE-1:0]      line_lvl,
  input  logic                     req_valid,
  input  logic [ID_W-1:0]          req_id,
  input  logic [1:0]               req_grp,
  input  logic                     req_ns,
  input  logic [NUM_SGI-1:0]       cfg_group,
  input  logic [NUM_SGI-1:0]       cfg_grpmod,
  input  logic [NUM_LINE-1:0]      cfg_edge,
  input  logic [ACC_W*NUM_SGI-1:0] cfg_nsacc,
  input  logic                     cfg_secdis,
  input  logic [NUM_IRQ-1:0]       pend_clr,
  output logic [NUM_IRQ-1:0]       pend_q,
  output logic [NUM_IRQ-1:0]       pend_set,
  output logic                     req_ack,
  output logic                     req_nak
);

  logic [NUM_LINE-1:0] line_rise;
  logic [NUM_SGI-1:0]  sgi_hit;
  logic                acc_c;
  logic                rej_c;
  logic [NUM_IRQ-1:0]  set_all;

  pip_line_edge #(.NUM_LINE(NUM_LINE)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .line_lvl  (line_lvl),
    .edge_mode (cfg_edge),
    .rise_set  (line_rise)
  );

  pip_sgi_gate #(
    .NUM_SGI (NUM_SGI),
    .ID_W    (ID_W),
    .ACC_W   (ACC_W)
  ) u_gate (
    .req_valid  (req_valid),
    .req_id     (req_id),
    .req_grp    (req_grp),
    .req_ns     (req_ns),
    .cfg_group  (cfg_group),
    .cfg_grpmod (cfg_grpmod),
    .cfg_nsacc  (cfg_nsacc),
    .cfg_secdis (cfg_secdis),
    .accept     (acc_c),
    .reject     (rej_c),
    .sgi_set    (sgi_hit)
  );

  assign set_all = {line_rise, sgi_hit};

  pip_pend_bank #(.NUM_IRQ(NUM_IRQ)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_now (set_all),
    .clr_now (pend_clr),
    .pend_q  (pend_q),
    .set_q   (pend_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ack <= 1'b0;
      req_nak <= 1'b0;
    end else begin
      req_ack <= acc_c;
      req_nak <= rej_c;
    end
  end

endmodule

// File: rtl/priv_irq_pend_chk.sv
module priv_irq_pend_chk #(
  parameter int NUM_SGI  = 16,
  parameter int NUM_LINE = 16,
  parameter int ID_W     = 5,
  localparam int NUM_IRQ = NUM_SGI + NUM_LINE
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_LINE-1:0] line_lvl,
  input logic                req_valid,
  input logic [ID_W-1:0]     req_id,
  input logic [NUM_LINE-1:0] cfg_edge,
  input logic [NUM_IRQ-1:0]  pend_q,
  input logic [NUM_IRQ-1:0]  pend_set,
  input logic                req_ack,
  input logic                req_nak
);

  AST_LINE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_set[NUM_IRQ-1:NUM_SGI] & ~$past(cfg_edge)) == '0)); // R3
  AST_LINE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_set[NUM_IRQ-1:NUM_SGI] & ~$past(line_lvl)) == '0)); // R2
  AST_BIG_ID_NAK: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_id >= ID_W'(NUM_SGI)) |=> (req_nak && pend_set[NUM_SGI-1:0] == '0)); // R4
  AST_SGI_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (pend_set[NUM_SGI-1:0] == '0)); // R9
  AST_SGI_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pend_set[NUM_SGI-1:0])); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ((pend_set & ~pend_q) == '0)); // R10
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (req_ack ^ req_nak)); // R11
  AST_NO_STRAY_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(req_ack || req_nak)); // R11

endmodule

bind priv_irq_pend priv_irq_pend_chk #(
  .NUM_SGI  (NUM_SGI),
  .NUM_LINE (NUM_LINE),
  .ID_W     (ID_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .line_lvl  (line_lvl),
  .req_valid (req_valid),
  .req_id    (req_id),
  .cfg_edge  (cfg_edge),
  .pend_q    (pend_q),
  .pend_set  (pend_set),
  .req_ack   (req_ack),
  .req_nak   (req_nak)
);

// File: tb/priv_irq_pend_test.sv
module priv_irq_pend_test;
  localparam int NS = 16;
  localparam int NL = 16;
  localparam int NI = NS + NL;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic [NL-1:0] line_lvl;
  logic          req_valid;
  logic [IW-1:0] req_id;
  logic [1:0]    req_grp;
  logic          req_ns;
  logic [NS-1:0] cfg_group, cfg_grpmod;
  logic [NL-1:0] cfg_edge;
  logic [2*NS-1:0] cfg_nsacc;
  logic          cfg_secdis;
  logic [NI-1:0] pend_clr;
  logic [NI-1:0] pend_q, pend_set;
  logic          req_ack, req_nak;

  int total = 0;
  int bad   = 0;
  logic [NI-1:0] m_pend;
  logic [NL-1:0] m_lvl;

  always #4 clk = ~clk;

  priv_irq_pend uut (
    .clk(clk), .rst(rst), .line_lvl(line_lvl), .req_valid(req_valid),
    .req_id(req_id), .req_grp(req_grp), .req_ns(req_ns),
    .cfg_group(cfg_group), .cfg_grpmod(cfg_grpmod), .cfg_edge(cfg_edge),
    .cfg_nsacc(cfg_nsacc), .cfg_secdis(cfg_secdis), .pend_clr(pend_clr),
    .pend_q(pend_q), .pend_set(pend_set), .req_ack(req_ack), .req_nak(req_nak)
  );

  function automatic logic model_accept(input logic [IW-1:0] id, input logic [1:0] rg_in,
                                        input logic ns, input logic [NS-1:0] g,
                                        input logic [NS-1:0] m, input logic [2*NS-1:0] acc,
                                        input logic sd);
    logic [1:0] cg, rg, a;
    int k;
    if (id >= IW'(NS)) return 1'b0;
    k  = int'(id);
    cg = g[k] ? 2'd2 : ((m[k] && !sd) ? 2'd1 : 2'd0);
    rg = rg_in;
    if (rg == 2'd1 && cg == 2'd0) rg = 2'd0;
    if (rg != cg) return 1'b0;
    if (ns && !sd) begin
      a = acc[2*k +: 2];
      if (cg == 2'd0 && a < 2'd1) return 1'b0;
      if (cg == 2'd1 && a < 2'd2) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply current inputs over one edge and compare against the model.
  task automatic step(input string tag);
    logic acc;
    logic [NI-1:0] setv, nextp;
    acc  = req_valid && model_accept(req_id, req_grp, req_ns, cfg_group, cfg_grpmod,
                                     cfg_nsacc, cfg_secdis);
    setv = {line_lvl & ~m_lvl & cfg_edge, {NS{1'b0}}};
    if (acc) setv[int'(req_id)] = 1'b1;
    nextp = (m_pend & ~pend_clr) | setv;
    @(posedge clk);
    @(negedge clk);
    m_pend = nextp;
    m_lvl  = line_lvl;
    check({tag, " pend_set"}, pend_set, setv);
    check({tag, " pend_q"}, pend_q, nextp);
    check({tag, " ack"}, 32'(req_ack), 32'(acc));
    check({tag, " nak"}, 32'(req_nak), 32'(req_valid && !acc));
  endtask

  task automatic req(input int id, input int grp, input logic ns);
    req_valid = 1'b1;
    req_id    = IW'(id);
    req_grp   = 2'(grp);
    req_ns    = ns;
  endtask

  task automatic idle();
    req_valid = 1'b0;
    pend_clr  = '0;
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    line_lvl = '0; req_valid = 1'b0; req_id = '0; req_grp = '0; req_ns = 1'b0;
    cfg_group = '0; cfg_grpmod = '0; cfg_edge = '0; cfg_nsacc = '0; cfg_secdis = 1'b0;
    pend_clr = '0;
    m_pend = '0; m_lvl = '0;
    // R1: line high and edge-configured throughout reset
    line_lvl[4] = 1'b1;
    cfg_edge[4] = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pend_q reset", pend_q, 32'd0);
    check("R1 pend_set reset", pend_set, 32'd0);
    check("R1 ack/nak reset", {30'd0, req_ack, req_nak}, 32'd0);
    rst = 1'b0;
    step("R1 level cleared by reset gives first edge");
    step("R3 unchanged level ignored");

    line_lvl[5] = 1'b1;
    step("R3 level-configured line gives no pulse");
    line_lvl[4] = 1'b0;
    step("R2 falling edge");
    line_lvl[4] = 1'b1;
    step("R2 rising edge on edge line");

    req(18, 0, 1'b0);
    step("R4 id above 15");
    req(19, 2, 1'b0);
    step("R4 id 19");

    req(3, 1, 1'b0);
    step("R5 group1 request on group0 interrupt");
    cfg_group[6] = 1'b1;
    req(6, 0, 1'b0);
    step("R6 group mismatch");
    req(6, 3, 1'b0);
    step("R6 group code 3");
    req(6, 2, 1'b0);
    step("R9 accepted non-secure group1");

    req(3, 0, 1'b1);
    step("R7 group0 level 0");
    cfg_nsacc[7:6] = 2'd1;
    step("R7 group0 level 1");
    cfg_grpmod[7] = 1'b1;
    cfg_nsacc[15:14] = 2'd1;
    req(7, 1, 1'b1);
    step("R7 secure group1 level 1");
    cfg_nsacc[15:14] = 2'd2;
    step("R7 secure group1 level 2");
    req(6, 2, 1'b1);
    step("R7 non-secure group1 level 0");

    cfg_secdis = 1'b1;
    cfg_nsacc = '0;
    req(2, 0, 1'b1);
    step("R8 no access check when security off");
    req(7, 1, 1'b1);
    step("R8 modifier ignored when security off");
    req(7, 2, 1'b0);
    step("R8 modifier ignored, group2 mismatch");
    cfg_secdis = 1'b0;

    req(3, 0, 1'b0);
    pend_clr = 32'h0000_0008;
    step("R10 set beats clear");
    idle();
    pend_clr = 32'h0010_0008;
    step("R10 clear alone");
    idle();
    step("R11 no request no response");

    // Constrained random phase
    for (int n = 0; n < 3000; n++) begin
      if (n % 8 == 0) begin
        cfg_group  = NS'($urandom);
        cfg_grpmod = NS'($urandom);
        cfg_edge   = NL'($urandom);
        cfg_nsacc  = $urandom;
        cfg_secdis = ($urandom % 4) == 0;
      end
      line_lvl ^= NL'($urandom & $urandom & $urandom);
      req_valid = ($urandom % 3) != 0;
      req_id    = IW'($urandom % 20);
      req_grp   = 2'($urandom);
      req_ns    = 1'($urandom);
      pend_clr  = $urandom & $urandom;
      step("R2 R3 R5 R6 R7 R8 R9 R10 R11 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule